// File: doc/BRIEF.md
# Flush-Free Cache Configuration Search Controller

This block finds a low-energy setting for a configurable cache. It searches greedily, one parameter at a time, and needs no cache flush. After a start pulse it drives a 7-bit configuration word to the cache. For each candidate word it asks the environment for an energy figure through two request/done handshakes. The first handshake covers a measurement window and the second covers the energy arithmetic. The controller keeps the lowest energy seen so far in an internal register and moves to the next parameter as soon as a candidate fails to beat it.

The parameters are visited in a fixed order: total size, then line size, then associativity, then way prediction. Every step only enlarges a setting. Because size and associativity never shrink during the search, no dirty line is ever stranded in a disabled way. Three nested state machines run the search. A parameter-level machine picks which field is being tuned. A value-level machine tracks which candidate of that field is under test. A calculation-level machine sequences the two handshakes. When the search ends, the controller holds the winning word on its outputs and raises a done flag.

Top module: `cache_tune_search`

## Requirements
- R1: While reset is held, and after it is released, the outputs are: `done` = 0, `measReq` = 0, `calcReq` = 0, `cfgOut` = 0 and `bestCfg` = 0.
- R2: The configuration word packs its fields as follows. Bits [1:0] hold the size code (0 = 2 KB, 1 = 4 KB, 2 = 8 KB). Bits [3:2] hold the line code (0 = 16 B, 1 = 32 B, 2 = 64 B). Bits [5:4] hold the associativity code (0 = 1 way, 1 = 2 ways, 2 = 4 ways). Bit [6] enables way prediction. In the cycle after `start` is sampled while idle or done, `measReq` is 1 and `cfgOut` is 0.
- R3: `measReq` and `calcReq` are each one-cycle pulses. `calcReq` rises only in the cycle after `measDone` is sampled high. The next candidate is requested only after `calcDone` returns. The number of calculation requests equals the number of candidates measured.
- R4: The first candidate always becomes the best. A later candidate replaces it only if its `energy` is strictly lower, so an equal value counts as no improvement. The size code is stepped 0, 1, 2 while energy keeps falling.
- R5: When a candidate is rejected, the configuration returns to the best word so far. The search then moves to the next parameter, and the line code is stepped 1, 2 on top of the chosen size.
- R6: The associativity code is stepped 1, 2 after the line step. A candidate is tried only if its code does not exceed the chosen size code. An illegal candidate ends the associativity step, so `cfgOut` is always a legal word.
- R7: Way prediction is tried once, last, and only if the chosen associativity code is nonzero. It stays on only if it lowers energy.
- R8: When the search ends, `done` rises and `cfgOut` equals `bestCfg`. Both hold, with no further requests, until the next `start`.
- R9: A `start` pulse during a search has no effect on the candidate order or on the result.
- R10: The best size, line and associativity codes never decrease during a search, and the best energy never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search when idle or done |
| measDone | input | 1 | Measurement window for the current word is complete |
| calcDone | input | 1 | Energy figure on `energy` is valid |
| energy | input | ENERGY_W | Energy estimate for the current word |
| measReq | output | 1 | Pulse: measure the current word |
| calcReq | output | 1 | Pulse: compute energy of the last measurement |
| cfgOut | output | 7 | Configuration word driven to the cache |
| bestCfg | output | 7 | Lowest-energy word found so far |
| done | output | 1 | Search finished; result valid |

## Verification
Some properties are checked by assertions on every cycle. These are the shape of the handshake pulses and the ordering of calculation after measurement. They also cover legality of every driven word, prediction only ever being on together with more than one way, the best energy never rising and the best fields never shrinking. The directed scenarios cover what only a full search can show. They check the exact sequence of candidate words under a given energy landscape, and the reaction to an equal energy. They also check the restore-on-rejection path, the skip of an illegal associativity and the absence of any prediction trial for a direct-mapped winner. Finally they check that a mid-search start pulse leaves the visited sequence and the result unchanged.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int FIELD_W = 2;
  localparam int CFG_W   = 3 * FIELD_W + 1;
  localparam int PRED_BIT = 3 * FIELD_W;
  localparam logic [FIELD_W-1:0] TOP_CODE = 2'd2;

  typedef enum logic [2:0] {P_IDLE, P_SIZE, P_LINE, P_ASSOC, P_PRED, P_DONE} paramState_t;
  typedef enum logic [1:0] {V_IFACE, V_ONE, V_TWO, V_THREE} valueState_t;
  typedef enum logic [2:0] {C_IDLE, C_REQ_MEAS, C_WAIT_MEAS, C_REQ_CALC, C_WAIT_CALC} calcState_t;
  typedef enum logic [1:0] {F_SIZE, F_LINE, F_ASSOC} field_t;

  typedef struct packed {
    logic   init;
    logic   capture;
    logic   restore;
    logic   step;
    field_t stepField;
    logic   predOn;
  } dpCtrl_t;
endpackage

// File: rtl/search_dp.sv
module search_dp
  import tune_pkg::*;
#(
  parameter int ENERGY_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  input  logic [ENERGY_W-1:0] energy,
  output logic [CFG_W-1:0]    cfgReg,
  output logic [CFG_W-1:0]    bestCfg,
  output logic                better
);
  logic [ENERGY_W-1:0] bestEnergy;
  logic                haveBest;
  logic [CFG_W-1:0]    cfgBase, cfgNext;
  logic                armed;

  assign better  = !haveBest || (energy < bestEnergy);
  assign cfgBase = ctl.restore ? bestCfg : cfgReg;

  always_comb begin
    cfgNext = cfgBase;
    if (ctl.init) begin
      cfgNext = '0;
    end else begin
      if (ctl.step)
        cfgNext[FIELD_W*int'(ctl.stepField) +: FIELD_W] =
          cfgBase[FIELD_W*int'(ctl.stepField) +: FIELD_W] + FIELD_W'(1);
      if (ctl.predOn)
        cfgNext[PRED_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg     <= '0;
      bestCfg    <= '0;
      bestEnergy <= '0;
      haveBest   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      armed  <= 1'b1;
      cfgReg <= cfgNext;
      if (ctl.init) begin
        bestCfg  <= '0;
        haveBest <= 1'b0;
      end else if (ctl.capture) begin
        bestCfg    <= cfgReg;
        bestEnergy <= energy;
        haveBest   <= 1'b1;
      end
    end
  end

  // R6: every word driven to the cache is a legal combination
  p_legal_cfg_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[1:0] <= TOP_CODE) && (cfgReg[3:2] <= TOP_CODE) && (cfgReg[5:4] <= cfgReg[1:0]));

  // R7: prediction is only ever enabled together with more than one way
  p_pred_needs_ways_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg[PRED_BIT] |-> (cfgReg[5:4] != 2'd0));

  // R10: best energy never rises within a search
  p_energy_nonrising_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(haveBest) && !$past(ctl.init)) |-> (bestEnergy <= $past(bestEnergy)));

  // R10: best fields never shrink within a search
  p_fields_monotone_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(ctl.init)) |->
      ((bestCfg[1:0] >= $past(bestCfg[1:0])) && (bestCfg[3:2] >= $past(bestCfg[3:2])) &&
       (bestCfg[5:4] >= $past(bestCfg[5:4]))));
endmodule

// File: rtl/search_ctrl.sv
module search_ctrl
  import tune_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             measDone,
  input  logic             calcDone,
  input  logic             better,
  input  logic [CFG_W-1:0] cfgCur,
  input  logic [CFG_W-1:0] bestCfg,
  output dpCtrl_t          ctl,
  output logic             measReq,
  output logic             calcReq,
  output logic             done
);
  paramState_t psm, psmNext;
  valueState_t vsm, vsmNext;
  calcState_t  csm, csmNext;
  logic [CFG_W-1:0] kept;
  logic canStepSame;
  field_t curField;

  assign measReq = (csm == C_REQ_MEAS);
  assign calcReq = (csm == C_REQ_CALC);
  assign done    = (psm == P_DONE);
  assign kept    = better ? cfgCur : bestCfg;

  always_comb begin
    curField    = F_SIZE;
    canStepSame = 1'b0;
    case (psm)
      P_SIZE:  begin curField = F_SIZE;  canStepSame = cfgCur[1:0] < TOP_CODE; end
      P_LINE:  begin curField = F_LINE;  canStepSame = cfgCur[3:2] < TOP_CODE; end
      P_ASSOC: begin curField = F_ASSOC; canStepSame = cfgCur[5:4] < cfgCur[1:0]; end
      default: ;
    endcase
  end

  always_comb begin
    psmNext = psm;
    vsmNext = vsm;
    csmNext = csm;
    ctl     = '0;
    case (csm)
      C_IDLE: begin
        if ((psm == P_IDLE || psm == P_DONE) && start) begin
          ctl.init = 1'b1;
          psmNext  = P_SIZE;
          vsmNext  = V_ONE;
          csmNext  = C_REQ_MEAS;
        end
      end
      C_REQ_MEAS:  csmNext = C_WAIT_MEAS;
      C_WAIT_MEAS: if (measDone) csmNext = C_REQ_CALC;
      C_REQ_CALC:  csmNext = C_WAIT_CALC;
      C_WAIT_CALC: begin
        if (calcDone) begin
          ctl.capture = better;
          ctl.restore = !better;
          csmNext     = C_REQ_MEAS;
          if (better && canStepSame) begin
            ctl.step      = 1'b1;
            ctl.stepField = curField;
            vsmNext       = valueState_t'(vsm + 2'd1);
          end else begin
            vsmNext = V_TWO;
            case (psm)
              P_SIZE: begin
                ctl.step = 1'b1; ctl.stepField = F_LINE; psmNext = P_LINE;
              end
              P_LINE: begin
                if (kept[5:4] < kept[1:0]) begin
                  ctl.step = 1'b1; ctl.stepField = F_ASSOC; psmNext = P_ASSOC;
                end else begin
                  psmNext = P_DONE;
                end
              end
              P_ASSOC: begin
                if (kept[5:4] != 2'd0) begin
                  ctl.predOn = 1'b1; psmNext = P_PRED;
                end else begin
                  psmNext = P_DONE;
                end
              end
              default: psmNext = P_DONE;
            endcase
            if (psmNext == P_DONE) begin
              vsmNext = V_IFACE;
              csmNext = C_IDLE;
            end
          end
        end
      end
      default: csmNext = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psm <= P_IDLE;
      vsm <= V_IFACE;
      csm <= C_IDLE;
    end else begin
      psm <= psmNext;
      vsm <= vsmNext;
      csm <= csmNext;
    end
  end

  // R3: measurement request lasts one cycle
  p_meas_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    measReq |=> !measReq);

  // R3: calculation is requested only right after a measurement completes
  p_calc_after_meas_r3: assert property (@(posedge clk) disable iff (!rstN)
    calcReq |-> $past(measDone));

  // R8: a finished search issues no requests
  p_quiet_when_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!measReq && !calcReq));

  // R3: an active calculation always has a candidate under test
  p_value_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csm != C_IDLE) |-> (vsm != V_IFACE));
endmodule

// File: rtl/cache_tune_search.sv
module cache_tune_search
  import tune_pkg::*;
#(
  parameter int ENERGY_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                measDone,
  input  logic                calcDone,
  input  logic [ENERGY_W-1:0] energy,
  output logic                measReq,
  output logic                calcReq,
  output logic [6:0]          cfgOut,
  output logic [6:0]          bestCfg,
  output logic                done
);
  dpCtrl_t          ctl;
  logic             better;
  logic [CFG_W-1:0] cfgReg, bestReg;

  search_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .measDone(measDone), .calcDone(calcDone),
    .better(better), .cfgCur(cfgReg), .bestCfg(bestReg), .ctl(ctl),
    .measReq(measReq), .calcReq(calcReq), .done(done)
  );

  search_dp #(.ENERGY_W(ENERGY_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .energy(energy),
    .cfgReg(cfgReg), .bestCfg(bestReg), .better(better)
  );

  assign cfgOut  = cfgReg;
  assign bestCfg = bestReg;
endmodule

// File: tb/tb_cache_tune_search.sv
module tb_cache_tune_search;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic measDone = 1'b0;
  logic calcDone = 1'b0;
  logic [31:0] energy = '0;
  logic measReq, calcReq, done;
  logic [6:0] cfgOut, bestCfg;

  int energyMap [128];
  int visitLog [16];
  int visitCnt = 0;
  int calcCnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tune_search dut (
    .clk(clk), .rstN(rstN), .start(start), .measDone(measDone), .calcDone(calcDone),
    .energy(energy), .measReq(measReq), .calcReq(calcReq), .cfgOut(cfgOut),
    .bestCfg(bestCfg), .done(done)
  );

  // environment: answers each request after a fixed delay
  initial begin
    int measCount = 0;
    int calcCount = 0;
    forever begin
      @(negedge clk);
      measDone = 1'b0;
      calcDone = 1'b0;
      if (measReq) begin
        if (visitCnt < 16) visitLog[visitCnt] = int'(cfgOut);
        visitCnt++;
        measCount = 2;
      end else if (measCount > 0) begin
        measCount--;
        if (measCount == 0) measDone = 1'b1;
      end
      if (calcReq) begin
        calcCnt++;
        calcCount = 2;
      end else if (calcCount > 0) begin
        calcCount--;
        if (calcCount == 0) begin
          energy   = 32'(energyMap[cfgOut]);
          calcDone = 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMap();
    for (int i = 0; i < 128; i++) energyMap[i] = 5000;
  endtask

  task automatic startSearch();
    visitCnt = 0;
    calcCnt  = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(measReq == 1'b1, "R2 measReq after start", int'(measReq), 1);
    check(cfgOut == 7'h00, "R2 initial word", int'(cfgOut), 0);
    check(done == 1'b0, "R8 done cleared by start", int'(done), 0);
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {req, " search completes"}, int'(done), 1);
  endtask

  task automatic checkResult(input string req, input int expCfg, input int expN, input int expV [16]);
    check(int'(bestCfg) == expCfg, {req, " bestCfg"}, int'(bestCfg), expCfg);
    check(int'(cfgOut) == expCfg, "R8 cfgOut equals best", int'(cfgOut), expCfg);
    check(visitCnt == expN, {req, " candidate count"}, visitCnt, expN);
    check(calcCnt == visitCnt, "R3 one calc per measurement", calcCnt, visitCnt);
    for (int i = 0; i < expN && i < 16; i++)
      check(visitLog[i] == expV[i], {req, " candidate order"}, visitLog[i], expV[i]);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && int'(cfgOut) == expCfg && !measReq, "R8 result held",
          int'(cfgOut), expCfg);
  endtask

  // R4 R5 R6 R7: energy falls at every step, all fields reach the top
  task automatic scenarioAllFalling();
    int expV [16] = '{8'h00, 8'h01, 8'h02, 8'h06, 8'h0A, 8'h1A, 8'h2A, 8'h6A,
                      0, 0, 0, 0, 0, 0, 0, 0};
    clearMap();
    energyMap[8'h00] = 900; energyMap[8'h01] = 800; energyMap[8'h02] = 700;
    energyMap[8'h06] = 600; energyMap[8'h0A] = 500; energyMap[8'h1A] = 400;
    energyMap[8'h2A] = 300; energyMap[8'h6A] = 200;
    startSearch();
    waitDone("R4");
    checkResult("R7 full climb", 8'h6A, 8, expV);
  endtask

  // R4: equal energy rejects 8 KB; R5 restore; R6 4-way skipped at 4 KB; R7 prediction rejected
  task automatic scenarioMidSize();
    int expV [16] = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h11, 8'h51,
                      0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    clearMap();
    energyMap[8'h00] = 900; energyMap[8'h01] = 800; energyMap[8'h02] = 800;
    energyMap[8'h05] = 850; energyMap[8'h11] = 700; energyMap[8'h51] = 750;
    startSearch();
    waitDone("R5");
    checkResult("R6 illegal skip", 8'h11, 6, expV);
  endtask

  // R5: line stepping on 2 KB; R7: direct-mapped winner never tries prediction
  task automatic scenarioSmall();
    int expV [16] = '{8'h00, 8'h01, 8'h04, 8'h08,
                      0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    clearMap();
    energyMap[8'h00] = 900; energyMap[8'h01] = 950;
    energyMap[8'h04] = 800; energyMap[8'h08] = 850;
    startSearch();
    waitDone("R5");
    checkResult("R7 no prediction trial", 8'h04, 4, expV);
  endtask

  // R9: a start pulse mid-search changes nothing
  task automatic scenarioStartWhileBusy();
    int expV [16] = '{8'h00, 8'h01, 8'h04, 8'h08,
                      0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    int n = 0;
    clearMap();
    energyMap[8'h00] = 900; energyMap[8'h01] = 950;
    energyMap[8'h04] = 800; energyMap[8'h08] = 850;
    startSearch();
    while (visitCnt < 2 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R9");
    checkResult("R9 start ignored", 8'h04, 4, expV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done idle", int'(done), 0);
    check(measReq == 1'b0 && calcReq == 1'b0, "R1 no requests", int'(measReq), 0);
    check(cfgOut == 7'h00, "R1 cfgOut reset", int'(cfgOut), 0);
    check(bestCfg == 7'h00, "R1 bestCfg reset", int'(bestCfg), 0);
    scenarioAllFalling();
    scenarioMidSize();
    scenarioSmall();
    scenarioStartWhileBusy();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule